// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block runs one external bus cycle at a time and decides how the cycle ends. A request latched from the processor side starts a six-state sequence (S0 to S5). The address strobe is driven low from S1 through S4. Three active-low termination inputs are sampled on the rising clock edge that leaves each even state: acknowledge, bus error and halt. The first sample is taken when S2 sees acknowledge or bus error; until then S2 repeats as a wait state. The second sample is taken at S4. The union of the two samples is resolved by a fixed priority into one of four outcomes.

After a halt outcome the controller stays parked until halt is released, and then returns to idle. After a retry outcome it waits for the halt release and then reruns the same access with the latched address, size and direction. Each rerun increments a retry counter. A bus-error outcome sets an exception flag that stays up until the processor side acknowledges it, so the exception may be taken late. An acknowledge or bus error that is still asserted from the previous cycle when the next cycle reaches S2 is reported as a protocol violation and does not end that cycle.

Top module: `bus_term_ctrl`

## Requirements
- R1: While the synchronous active-high reset is high, and in the cycle after it, the address strobe is high, term_valid, halted, retry_pend and berr_exc are 0, retry_cnt is 0, and bus_state reads 7 (idle).
- R2: A request accepted in idle gives bus_state 0 on the next cycle, then 1 and then 2. as_n is low exactly while bus_state is 1 to 4, and bus_state reads 7 outside S0 to S5.
- R3: S2 repeats, one clock per repetition, for as long as neither acknowledge nor bus error is asserted. Halt alone does not end S2.
- R4: term_valid is high for one cycle, in S5 (bus_state 5). term_code is 0 (normal) when neither sample shows bus error or halt.
- R5: term_code is 1 (halt) when a sample shows halt and neither sample shows bus error. Afterwards halted stays 1 while halt_n is low, and the block is idle one cycle after halt_n goes high.
- R6: term_code is 2 (error) when a sample shows bus error and neither sample shows halt. berr_exc goes to 1 on the cycle after S5 and stays 1 until a cycle with exc_ack high.
- R7: term_code is 3 (retry) when bus error and halt both appear across the two samples, in either order. retry_pend then stays 1 while halt_n is low. On the cycle after halt_n goes high, bus_state is 0 and bus_addr, bus_size and bus_write are unchanged.
- R8: The outcome priority is retry, then error, then halt, then normal. It is applied to the bitwise OR of the S2 and S4 samples.
- R9: If acknowledge or bus error is asserted at the edge leaving S5 and stays asserted into S2 of the next cycle, proto_viol is 1 in that S2 and the stale input does not end S2. Once the input has been seen released, a new assertion is honoured.
- R10: retry_cnt clears when a new request is accepted and increments on each rerun. With RETRY_SAT=1 it holds at its maximum instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor-side request, accepted when req_ready is 1 |
| req_addr | input | ADDR_W | Request address |
| req_size | input | SIZE_W | Request size code |
| req_write | input | 1 | Request direction, 1 for write |
| exc_ack | input | 1 | Clears the bus-error exception flag |
| ack_n | input | 1 | Data acknowledge, active low |
| berr_n | input | 1 | Bus error, active low |
| halt_n | input | 1 | Halt, active low |
| req_ready | output | 1 | Controller is idle and can take a request |
| as_n | output | 1 | Address strobe, active low |
| bus_state | output | 3 | Current bus state 0 to 5, or 7 outside a cycle |
| bus_addr | output | ADDR_W | Latched address of the current access |
| bus_size | output | SIZE_W | Latched size of the current access |
| bus_write | output | 1 | Latched direction of the current access |
| term_valid | output | 1 | Termination result valid (S5) |
| term_code | output | 2 | 0 normal, 1 halt, 2 error, 3 retry |
| halted | output | 1 | Parked after a halt termination |
| retry_pend | output | 1 | Waiting for halt release before a rerun |
| berr_exc | output | 1 | Bus-error exception pending |
| retry_cnt | output | RCNT_W | Number of reruns of the current request |
| proto_viol | output | 1 | Stale acknowledge or bus error seen in S2 |

## Verification
The bench builds the block with an 8-bit address, a 2-bit size, a 2-bit saturating retry counter and the stale check enabled. It sweeps every first sample that can end S2 against all eight second samples, with a varying number of wait states, so each outcome arises from several distinct input orders. The 2-bit counter lets four back-to-back retries reach and hold the saturation value. Holding acknowledge across a cycle boundary exercises the stale-input path.

// File: rtl/btc_pkg.sv
package btc_pkg;

   typedef enum logic [3:0] {
      ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5, ST_HALTW, ST_RETRYW
   } btc_state_e;

   typedef enum logic [1:0] {
      TERM_NORMAL = 2'd0,
      TERM_HALT   = 2'd1,
      TERM_ERROR  = 2'd2,
      TERM_RETRY  = 2'd3
   } btc_term_e;

   typedef struct packed {
      logic ack;
      logic berr;
      logic halt;
   } btc_smp_t;

   localparam int unsigned BUS_STATE_W = 3;
   localparam logic [BUS_STATE_W-1:0] BUS_STATE_IDLE = 3'd7;

   function automatic btc_term_e btc_prio(input btc_smp_t s);
      if (s.berr && s.halt) return TERM_RETRY;
      else if (s.berr)      return TERM_ERROR;
      else if (s.halt)      return TERM_HALT;
      else                  return TERM_NORMAL;
   endfunction

endpackage

// File: rtl/btc_stale_filter.sv
module btc_stale_filter
   #(parameter bit ENABLE = 1'b1)
   (
   input  logic clk,
   input  logic rst,
   input  logic cyc_end,
   input  logic in_s2,
   input  logic ack_a,
   input  logic berr_a,
   output logic ack_e,
   output logic berr_e,
   output logic viol
   );

   generate
      if (ENABLE) begin : g_filter
         logic ack_st, berr_st;
         always_ff @(posedge clk) begin
            if (rst) begin
               ack_st  <= 1'b0;
               berr_st <= 1'b0;
            end else if (cyc_end) begin
               ack_st  <= ack_a;
               berr_st <= berr_a;
            end else begin
               if (!ack_a)  ack_st  <= 1'b0;
               if (!berr_a) berr_st <= 1'b0;
            end
         end
         assign ack_e  = ack_a  & ~ack_st;
         assign berr_e = berr_a & ~berr_st;
         assign viol   = in_s2 & ((ack_a & ack_st) | (berr_a & berr_st));
      end else begin : g_pass
         assign ack_e  = ack_a;
         assign berr_e = berr_a;
         assign viol   = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/btc_resolve.sv
module btc_resolve
   import btc_pkg::*;
   (
   input  logic      clk,
   input  logic      rst,
   input  logic      samp1_en,
   input  logic      samp2_en,
   input  btc_smp_t  smp_now,
   output btc_term_e code_q
   );

   btc_smp_t first_q;
   btc_smp_t merged;

   assign merged = first_q | smp_now;

   always_ff @(posedge clk) begin
      if (rst) begin
         first_q <= '0;
         code_q  <= TERM_NORMAL;
      end else begin
         if (samp1_en) first_q <= smp_now;
         if (samp2_en) code_q  <= btc_prio(merged);
      end
   end

endmodule

// File: rtl/btc_retry_count.sv
module btc_retry_count
   #(parameter int unsigned WIDTH = 4,
     parameter bit          SAT   = 1'b1)
   (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             inc,
   output logic [WIDTH-1:0] cnt
   );

   localparam logic [WIDTH-1:0] CNT_MAX = '1;

   logic do_inc;

   generate
      if (SAT) begin : g_sat
         assign do_inc = inc && (cnt != CNT_MAX);
      end else begin : g_wrap
         assign do_inc = inc;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) cnt <= '0;
      else if (do_inc) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/btc_seq.sv
module btc_seq
   import btc_pkg::*;
   #(parameter int unsigned ADDR_W = 24,
     parameter int unsigned SIZE_W = 2)
   (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              req_write,
   input  logic              go_term,
   input  logic              halt_a,
   input  btc_term_e         code,
   output btc_state_e        state,
   output logic              accept,
   output logic              rerun,
   output logic [ADDR_W-1:0] addr_q,
   output logic [SIZE_W-1:0] size_q,
   output logic              write_q
   );

   assign accept = (state == ST_IDLE) && req_valid;
   assign rerun  = (state == ST_RETRYW) && !halt_a;

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         addr_q  <= '0;
         size_q  <= '0;
         write_q <= 1'b0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            size_q  <= req_size;
            write_q <= req_write;
         end
         case (state)
            ST_IDLE:   if (req_valid) state <= ST_S0;
            ST_S0:     state <= ST_S1;
            ST_S1:     state <= ST_S2;
            ST_S2:     if (go_term) state <= ST_S3;
            ST_S3:     state <= ST_S4;
            ST_S4:     state <= ST_S5;
            ST_S5: begin
               case (code)
                  TERM_HALT:  state <= ST_HALTW;
                  TERM_RETRY: state <= ST_RETRYW;
                  default:    state <= ST_IDLE;
               endcase
            end
            ST_HALTW:  if (!halt_a) state <= ST_IDLE;
            ST_RETRYW: if (!halt_a) state <= ST_S0;
            default:   state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
   import btc_pkg::*;
   #(parameter int unsigned ADDR_W      = 24,
     parameter int unsigned SIZE_W      = 2,
     parameter int unsigned RCNT_W      = 4,
     parameter bit          RETRY_SAT   = 1'b1,
     parameter bit          STALE_CHECK = 1'b1)
   (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              req_write,
   input  logic              exc_ack,
   input  logic              ack_n,
   input  logic              berr_n,
   input  logic              halt_n,
   output logic              req_ready,
   output logic              as_n,
   output logic [2:0]        bus_state,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [SIZE_W-1:0] bus_size,
   output logic              bus_write,
   output logic              term_valid,
   output logic [1:0]        term_code,
   output logic              halted,
   output logic              retry_pend,
   output logic              berr_exc,
   output logic [RCNT_W-1:0] retry_cnt,
   output logic              proto_viol
   );

   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("ADDR_W must be at least 1");
   end
   if (SIZE_W < 1) begin : g_bad_size_w
      $error("SIZE_W must be at least 1");
   end
   if (RCNT_W < 1 || RCNT_W > 16) begin : g_bad_rcnt_w
      $error("RCNT_W must lie in 1..16");
   end

   btc_state_e state;
   btc_term_e  code_q;
   btc_smp_t   smp_now;
   logic ack_a, berr_a, halt_a;
   logic ack_e, berr_e;
   logic in_s2, in_s4, in_s5;
   logic go_term, accept, rerun;

   assign ack_a  = ~ack_n;
   assign berr_a = ~berr_n;
   assign halt_a = ~halt_n;

   assign in_s2 = (state == ST_S2);
   assign in_s4 = (state == ST_S4);
   assign in_s5 = (state == ST_S5);

   btc_stale_filter #(.ENABLE(STALE_CHECK)) u_stale (
      .clk     (clk),
      .rst     (rst),
      .cyc_end (in_s5),
      .in_s2   (in_s2),
      .ack_a   (ack_a),
      .berr_a  (berr_a),
      .ack_e   (ack_e),
      .berr_e  (berr_e),
      .viol    (proto_viol)
   );

   assign smp_now = '{ack: ack_e, berr: berr_e, halt: halt_a};
   assign go_term = in_s2 && (ack_e || berr_e);

   btc_resolve u_resolve (
      .clk      (clk),
      .rst      (rst),
      .samp1_en (go_term),
      .samp2_en (in_s4),
      .smp_now  (smp_now),
      .code_q   (code_q)
   );

   btc_seq #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_size  (req_size),
      .req_write (req_write),
      .go_term   (go_term),
      .halt_a    (halt_a),
      .code      (code_q),
      .state     (state),
      .accept    (accept),
      .rerun     (rerun),
      .addr_q    (bus_addr),
      .size_q    (bus_size),
      .write_q   (bus_write)
   );

   btc_retry_count #(.WIDTH(RCNT_W), .SAT(RETRY_SAT)) u_rcnt (
      .clk (clk),
      .rst (rst),
      .clr (accept),
      .inc (rerun),
      .cnt (retry_cnt)
   );

   always_ff @(posedge clk) begin
      if (rst)                                  berr_exc <= 1'b0;
      else if (in_s5 && code_q == TERM_ERROR)   berr_exc <= 1'b1;
      else if (exc_ack)                         berr_exc <= 1'b0;
   end

   always_comb begin
      case (state)
         ST_S0:   bus_state = 3'd0;
         ST_S1:   bus_state = 3'd1;
         ST_S2:   bus_state = 3'd2;
         ST_S3:   bus_state = 3'd3;
         ST_S4:   bus_state = 3'd4;
         ST_S5:   bus_state = 3'd5;
         default: bus_state = BUS_STATE_IDLE;
      endcase
   end

   assign as_n       = !(state == ST_S1 || state == ST_S2 ||
                         state == ST_S3 || state == ST_S4);
   assign req_ready  = (state == ST_IDLE);
   assign term_valid = in_s5;
   assign term_code  = code_q;
   assign halted     = (state == ST_HALTW);
   assign retry_pend = (state == ST_RETRYW);

endmodule

// File: rtl/bus_term_ctrl_chk.sv
module bus_term_ctrl_chk
   #(parameter int unsigned ADDR_W = 24)
   (
   input logic              clk,
   input logic              rst,
   input logic              ack_n,
   input logic              berr_n,
   input logic              halt_n,
   input logic              as_n,
   input logic [2:0]        bus_state,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              term_valid,
   input logic [1:0]        term_code,
   input logic              halted,
   input logic              retry_pend,
   input logic              berr_exc,
   input logic              proto_viol
   );

   // R1: reset leaves the strobe high and no result pending
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (as_n && !term_valid && !berr_exc && !halted && !retry_pend));

   // R2: strobe high whenever parked or reporting
   p_strobe_idle_r2: assert property (@(posedge clk) disable iff (rst)
      (term_valid || halted || retry_pend) |-> as_n);

   // R3: no termination input keeps S2 repeating
   p_wait_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_state == 3'd2 && ack_n && berr_n) |=> bus_state == 3'd2);

   // R4: result is a single-cycle pulse
   p_term_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      term_valid |=> !term_valid);

   // R5: halt park persists while halt is held
   p_halt_park_r5: assert property (@(posedge clk) disable iff (rst)
      (halted && !halt_n) |=> halted);

   // R6: exception flag only rises after an error result
   p_exc_source_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(berr_exc) |-> ($past(term_valid) && $past(term_code) == 2'd2));

   // R7: address kept while waiting to rerun
   p_retry_addr_r7: assert property (@(posedge clk) disable iff (rst)
      retry_pend |=> $stable(bus_addr));

   // R7: halt release restarts at S0
   p_retry_restart_r7: assert property (@(posedge clk) disable iff (rst)
      (retry_pend && halt_n) |=> (bus_state == 3'd0 && as_n));

   // R9: stale input flagged only inside S2 with the strobe low
   p_stale_in_s2_r9: assert property (@(posedge clk) disable iff (rst)
      proto_viol |-> (bus_state == 3'd2 && !as_n));

endmodule

bind bus_term_ctrl bus_term_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .ack_n      (ack_n),
   .berr_n     (berr_n),
   .halt_n     (halt_n),
   .as_n       (as_n),
   .bus_state  (bus_state),
   .bus_addr   (bus_addr),
   .term_valid (term_valid),
   .term_code  (term_code),
   .halted     (halted),
   .retry_pend (retry_pend),
   .berr_exc   (berr_exc),
   .proto_viol (proto_viol)
);

// File: tb/bus_term_ctrl_tb.sv
`timescale 1ns/1ps
module bus_term_ctrl_tb;

   localparam int AW = 8;
   localparam int SW = 2;
   localparam int RW = 2;

   logic clk = 1'b0;
   logic rst;
   logic req_valid, req_write, exc_ack, ack_n, berr_n, halt_n;
   logic [AW-1:0] req_addr;
   logic [SW-1:0] req_size;
   logic req_ready, as_n, bus_write, term_valid, halted, retry_pend, berr_exc, proto_viol;
   logic [2:0] bus_state;
   logic [AW-1:0] bus_addr;
   logic [SW-1:0] bus_size;
   logic [1:0] term_code;
   logic [RW-1:0] retry_cnt;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bus_term_ctrl #(.ADDR_W(AW), .SIZE_W(SW), .RCNT_W(RW),
                   .RETRY_SAT(1'b1), .STALE_CHECK(1'b1)) u_dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
      .req_size(req_size), .req_write(req_write), .exc_ack(exc_ack),
      .ack_n(ack_n), .berr_n(berr_n), .halt_n(halt_n),
      .req_ready(req_ready), .as_n(as_n), .bus_state(bus_state),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_write(bus_write),
      .term_valid(term_valid), .term_code(term_code), .halted(halted),
      .retry_pend(retry_pend), .berr_exc(berr_exc), .retry_cnt(retry_cnt),
      .proto_viol(proto_viol));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic start_req(input logic [AW-1:0] a, input logic [SW-1:0] s, input logic w);
      req_valid = 1'b1; req_addr = a; req_size = s; req_write = w;
      tick();
      req_valid = 1'b0;
      chk("R2", "state after accept", bus_state, 0);
      chk("R2", "strobe in S0", as_n, 1);
   endtask

   task automatic to_s2();
      tick();
      chk("R2", "state S1", bus_state, 1);
      chk("R2", "strobe in S1", as_n, 0);
      tick();
      chk("R2", "state S2", bus_state, 2);
   endtask

   // samples: bit2 ack, bit1 berr, bit0 halt (1 = asserted)
   task automatic finish(input logic [2:0] s1, input logic [2:0] s2, input int nwait,
                         input int exp_code);
      for (int i = 0; i < nwait; i++) begin
         ack_n = 1'b1; berr_n = 1'b1; halt_n = ~s1[0];
         tick();
         chk("R3", "wait state hold", bus_state, 2);
      end
      ack_n = ~s1[2]; berr_n = ~s1[1]; halt_n = ~s1[0];
      tick();
      chk("R2", "state S3", bus_state, 3);
      ack_n = ~s2[2]; berr_n = ~s2[1]; halt_n = ~s2[0];
      tick();
      chk("R2", "state S4", bus_state, 4);
      tick();
      chk("R4", "term_valid in S5", term_valid, 1);
      chk("R8", "term_code", term_code, exp_code);
      chk("R2", "strobe in S5", as_n, 1);
      ack_n = 1'b1; berr_n = 1'b1;
      halt_n = (exp_code == 1 || exp_code == 3) ? 1'b0 : 1'b1;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; exc_ack = 1'b0;
      ack_n = 1'b1; berr_n = 1'b1; halt_n = 1'b1; req_addr = '0; req_size = '0;
      repeat (3) @(negedge clk);
      chk("R1", "as_n in reset", as_n, 1);
      chk("R1", "bus_state in reset", bus_state, 7);
      chk("R1", "term_valid in reset", term_valid, 0);
      chk("R1", "flags in reset", {halted, retry_pend, berr_exc}, 0);
      chk("R1", "retry_cnt in reset", retry_cnt, 0);
      rst = 1'b0;
      tick();
      chk("R1", "idle after reset", bus_state, 7);
      chk("R1", "ready after reset", req_ready, 1);

      // R8 sweep: every ending first sample against every second sample
      for (int a = 1; a < 8; a++) begin
         for (int b = 0; b < 8; b++) begin
            logic [2:0] s1, s2, u;
            int exp;
            logic [AW-1:0] adr;
            s1 = a[2:0]; s2 = b[2:0];
            if (!(s1[2] || s1[1])) continue;
            u = s1 | s2;
            exp = (u[1] && u[0]) ? 3 : u[1] ? 2 : u[0] ? 1 : 0;
            adr = AW'(a * 16 + b);
            start_req(adr, SW'(b), a[0]);
            to_s2();
            finish(s1, s2, (a + b) % 3, exp);
            tick();
            case (exp)
               0: chk("R4", "idle after normal", bus_state, 7);
               1: begin
                  chk("R5", "halted held", halted, 1);
                  chk("R5", "strobe while halted", as_n, 1);
                  tick();
                  chk("R5", "still halted", halted, 1);
                  halt_n = 1'b1;
                  tick();
                  chk("R5", "halted released", halted, 0);
                  chk("R5", "idle after halt", bus_state, 7);
               end
               2: begin
                  chk("R6", "berr_exc set", berr_exc, 1);
                  chk("R6", "idle after error", bus_state, 7);
                  tick();
                  chk("R6", "berr_exc kept", berr_exc, 1);
                  exc_ack = 1'b1;
                  tick();
                  exc_ack = 1'b0;
                  chk("R6", "berr_exc cleared", berr_exc, 0);
               end
               default: begin
                  chk("R7", "retry_pend", retry_pend, 1);
                  chk("R7", "no exception on retry", berr_exc, 0);
                  halt_n = 1'b1;
                  tick();
                  chk("R7", "rerun S0", bus_state, 0);
                  chk("R7", "addr kept", bus_addr, adr);
                  chk("R7", "size kept", bus_size, b % 4);
                  chk("R7", "dir kept", bus_write, a % 2);
                  chk("R10", "retry_cnt one", retry_cnt, 1);
                  to_s2();
                  finish(3'b100, 3'b100, 0, 0);
                  tick();
                  chk("R7", "idle after rerun", bus_state, 7);
               end
            endcase
         end
      end

      // R3: halt alone does not end S2
      start_req(8'h3C, 2'd1, 1'b0);
      to_s2();
      halt_n = 1'b0;
      tick(); tick();
      chk("R3", "halt alone waits", bus_state, 2);
      halt_n = 1'b1;
      finish(3'b100, 3'b000, 1, 0);
      tick();

      // R9: acknowledge held across the cycle boundary
      start_req(8'h55, 2'd2, 1'b1);
      to_s2();
      finish(3'b100, 3'b100, 0, 0);
      ack_n = 1'b0;
      tick();
      chk("R9", "idle before stale", bus_state, 7);
      start_req(8'h56, 2'd2, 1'b1);
      to_s2();
      chk("R9", "proto_viol raised", proto_viol, 1);
      tick();
      chk("R9", "stale ack ignored", bus_state, 2);
      ack_n = 1'b1;
      tick();
      chk("R9", "proto_viol cleared", proto_viol, 0);
      chk("R9", "still waiting", bus_state, 2);
      finish(3'b100, 3'b000, 0, 0);
      tick();
      chk("R9", "idle after fresh ack", bus_state, 7);

      // R10: saturation after repeated retries
      start_req(8'hA7, 2'd3, 1'b0);
      chk("R10", "cleared on accept", retry_cnt, 0);
      to_s2();
      finish(3'b011, 3'b011, 0, 3);
      for (int k = 1; k <= 4; k++) begin
         tick();
         chk("R7", "retry_pend loop", retry_pend, 1);
         halt_n = 1'b1;
         tick();
         chk("R10", "retry_cnt value", retry_cnt, (k < 3) ? k : 3);
         chk("R7", "addr kept loop", bus_addr, 8'hA7);
         to_s2();
         if (k < 4) finish(3'b011, 3'b010, 0, 3);
         else       finish(3'b100, 3'b000, 0, 0);
      end
      tick();
      chk("R10", "idle after saturation", bus_state, 7);
      start_req(8'h01, 2'd0, 1'b0);
      chk("R10", "cleared on new request", retry_cnt, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule